// File: doc/BRIEF.md
# SDRAM Open-Row Command Sequencer

This block converts single read and write requests from a host bus into SDRAM command sequences. The host presents an address, a write flag, write data and byte enables, and holds its request until the block answers with a one-cycle done pulse. Each request moves exactly one bus-width word. Refresh, mode-register setup and bursts are handled elsewhere.

A run-time mode input picks one of two row policies. With the mode low, every access opens its row, issues the column command with the precharge flag set, and waits out write recovery or read latency plus the precharge time before it completes. With the mode high, rows are left open. The block remembers the open row of every bank and sorts each request into one of three cases. A hit in the open row goes straight to the column command. A request to a bank with nothing open activates the row first. A request to a different row in an open bank precharges that bank, activates the new row, and then issues the column command.

When the mode is lowered while rows are open, the block precharges all banks before it takes the next request. After that, and after reset, no row is considered open.

Top module: `sdram_open_row_seq`

## Requirements
- R1: After reset the command pins encode NOP, reqDone is low, sdDqOe is low and sdDqm is all ones. The pin encoding is chip select low with RAS/CAS/WE high for NOP, RAS only low for ACT, CAS only low for READ, CAS and WE low for WRITE, and RAS and WE low for PRE.
- R2: reqAddr holds the column in its low COL_W bits, the row in the next ROW_W bits and the bank in the top BANK_W bits. ACT drives the row on sdAddr. READ and WRITE drive the column on sdAddr, zero-extended. Every command drives the bank on sdBank. Each access ends with reqDone high for exactly one cycle, and no command is issued in that cycle.
- R3: With openMode low, an access issues ACT and then a column command with sdA10 high, and no PRE.
- R4: The column command follows ACT by exactly T_RCD cycles. reqDone rises T_WR cycles after WRITE, or T_CL+1 cycles after READ, plus T_RP more cycles when openMode is low.
- R5: With openMode high, column commands carry sdA10 low.
- R6: With openMode high, an access to a bank with no open row issues ACT and then the column command, with no PRE.
- R7: With openMode high, an access to the open row of its bank issues only the column command.
- R8: With openMode high, an access to another row of an open bank issues PRE to that bank with sdA10 low, then ACT exactly T_RP cycles later, then the column command.
- R9: Each bank keeps its own open row. Opening a row in one bank leaves the open row of every other bank intact.
- R10: During the WRITE cycle, sdDqOut carries the write data, sdDqOe is high and sdDqm is the bitwise inverse of reqBe. sdDqOe is low in every other cycle.
- R11: When reqDone rises for a read, rdData holds the sdDqIn value sampled T_CL cycles after the READ command.
- R12: When openMode is low in idle and any row is open, a PRE with sdA10 high is issued before the next access. All rows are then treated as closed.
- R13: Reset leaves no row open, so the first open-mode access to any row issues ACT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| openMode | input | 1 | 1 keeps rows open, 0 auto-precharges every access |
| reqValid | input | 1 | Request pending, held until reqDone |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | BANK_W+ROW_W+COL_W | Bank, row and column address |
| reqWdata | input | DATA_W | Write data |
| reqBe | input | DATA_W/8 | Byte enables for the write |
| reqDone | output | 1 | One-cycle completion pulse |
| rdData | output | DATA_W | Read data, valid at reqDone |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdA10 | output | 1 | Precharge flag on the A10 pin |
| sdBank | output | BANK_W | Bank select |
| sdAddr | output | ROW_W | Row or column address |
| sdDqm | output | DATA_W/8 | Byte-lane mask |
| sdDqOut | output | DATA_W | Data driven to the device |
| sdDqOe | output | 1 | Data output enable |
| sdDqIn | input | DATA_W | Data from the device |

## Verification
Accesses in auto-precharge mode are compared against the open-row mode, which separates the two settings of the precharge flag and the two completion times. In open-row mode the bench applies an empty bank, a hit, a hit after another bank was opened, and a miss. Each case produces a different command list, so the tests tell apart a wrong hit decision, a missing PRE, a table shared between banks and a wrong PRE-to-ACT spacing. The bench drives sdDqIn with a value that changes every cycle, which pins down the read capture cycle. Switching the mode off with rows open, and resetting with a row open, shows whether the table is cleared.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE
  } sdCmdE;

  // strobes from control to datapath
  typedef struct packed {
    sdCmdE cmd;
    logic  a10;
    logic  selRow;
    logic  latch;
    logic  capture;
  } seqStrobeT;
endpackage

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int T_RCD  = 2,
  parameter int T_RP   = 3,
  parameter int T_WR   = 2,
  parameter int T_CL   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              openMode,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [BANK_W-1:0] liveBank,
  input  logic [ROW_W-1:0]  liveRow,
  input  logic [BANK_W-1:0] curBank,
  input  logic [ROW_W-1:0]  curRow,
  output seqStrobeT         stb,
  output logic              reqDone
);
  localparam int NBANK = 1 << BANK_W;
  localparam int MAXT  = (T_RCD > T_RP) ?
                         ((T_RCD > T_WR) ? ((T_RCD > T_CL) ? T_RCD : T_CL) : ((T_WR > T_CL) ? T_WR : T_CL)) :
                         ((T_RP > T_WR) ? ((T_RP > T_CL) ? T_RP : T_CL) : ((T_WR > T_CL) ? T_WR : T_CL));
  localparam int CNT_W = $clog2(MAXT + 2);

  typedef enum logic [3:0] {
    S_IDLE, S_PALL, S_PALLW, S_PRE, S_RPW, S_ACT, S_RCD, S_COL, S_DAT, S_AP, S_DONE
  } stateE;

  stateE             state;
  logic [CNT_W-1:0]  waitCnt;
  logic              modeLat;
  logic              isWr;
  logic [NBANK-1:0]  rowValid;
  logic [ROW_W-1:0]  rowTag [NBANK];

  // per-bank open-row table
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic             vld;
    logic [ROW_W-1:0] tag;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vld <= 1'b0;
        tag <= '0;
      end else if (state == S_PALL) begin
        vld <= 1'b0;
      end else if (curBank == BANK_W'(b)) begin
        if (state == S_PRE) begin
          vld <= 1'b0;
        end else if (state == S_ACT && modeLat) begin
          vld <= 1'b1;
          tag <= curRow;
        end
      end
    end
    assign rowValid[b] = vld;
    assign rowTag[b]   = tag;
  end

  logic anyOpen, needPall, rowHit, accept;
  assign anyOpen  = |rowValid;
  assign needPall = !openMode && anyOpen;
  assign rowHit   = rowValid[liveBank] && (rowTag[liveBank] == liveRow);
  assign accept   = (state == S_IDLE) && reqValid && !needPall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      waitCnt <= '0;
      modeLat <= 1'b0;
      isWr    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (needPall) begin
            state <= S_PALL;
          end else if (reqValid) begin
            modeLat <= openMode;
            isWr    <= reqWrite;
            if (!openMode)                 state <= S_ACT;
            else if (rowHit)               state <= S_COL;
            else if (rowValid[liveBank])   state <= S_PRE;
            else                           state <= S_ACT;
          end
        end
        S_PALL: begin
          waitCnt <= CNT_W'(T_RP - 1);
          state   <= S_PALLW;
        end
        S_PALLW: begin
          if (waitCnt == CNT_W'(1)) state <= S_IDLE;
          else                      waitCnt <= waitCnt - 1'b1;
        end
        S_PRE: begin
          waitCnt <= CNT_W'(T_RP - 1);
          state   <= S_RPW;
        end
        S_RPW: begin
          if (waitCnt == CNT_W'(1)) state <= S_ACT;
          else                      waitCnt <= waitCnt - 1'b1;
        end
        S_ACT: begin
          waitCnt <= CNT_W'(T_RCD - 1);
          state   <= S_RCD;
        end
        S_RCD: begin
          if (waitCnt == CNT_W'(1)) state <= S_COL;
          else                      waitCnt <= waitCnt - 1'b1;
        end
        S_COL: begin
          waitCnt <= isWr ? CNT_W'(T_WR - 1) : CNT_W'(T_CL);
          state   <= S_DAT;
        end
        S_DAT: begin
          if (waitCnt == CNT_W'(1)) begin
            if (modeLat) begin
              state <= S_DONE;
            end else begin
              waitCnt <= CNT_W'(T_RP);
              state   <= S_AP;
            end
          end else begin
            waitCnt <= waitCnt - 1'b1;
          end
        end
        S_AP: begin
          if (waitCnt == CNT_W'(1)) state <= S_DONE;
          else                      waitCnt <= waitCnt - 1'b1;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb         = '0;
    stb.cmd     = CMD_NOP;
    stb.latch   = accept;
    stb.capture = (state == S_DAT) && !isWr && (waitCnt == CNT_W'(1));
    unique case (state)
      S_ACT:  begin stb.cmd = CMD_ACT; stb.selRow = 1'b1; end
      S_PRE:  begin stb.cmd = CMD_PRE; stb.a10 = 1'b0; end
      S_PALL: begin stb.cmd = CMD_PRE; stb.a10 = 1'b1; end
      S_COL:  begin stb.cmd = isWr ? CMD_WR : CMD_RD; stb.a10 = !modeLat; end
      default: ;
    endcase
  end

  assign reqDone = (state == S_DONE);
endmodule

// File: rtl/sdram_seq_dpath.sv
module sdram_seq_dpath
  import sdram_seq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  seqStrobeT                     stb,
  input  logic [BANK_W+ROW_W+COL_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]             reqWdata,
  input  logic [DATA_W/8-1:0]           reqBe,
  input  logic [DATA_W-1:0]             sdDqIn,
  output logic [BANK_W-1:0]             liveBank,
  output logic [ROW_W-1:0]              liveRow,
  output logic [BANK_W-1:0]             curBank,
  output logic [ROW_W-1:0]              curRow,
  output logic [DATA_W-1:0]             rdData,
  output logic                          sdCsN,
  output logic                          sdRasN,
  output logic                          sdCasN,
  output logic                          sdWeN,
  output logic                          sdA10,
  output logic [BANK_W-1:0]             sdBank,
  output logic [ROW_W-1:0]              sdAddr,
  output logic [DATA_W/8-1:0]           sdDqm,
  output logic [DATA_W-1:0]             sdDqOut,
  output logic                          sdDqOe
);
  localparam int BE_W = DATA_W / 8;

  logic [COL_W-1:0]  colLat;
  logic [DATA_W-1:0] wdLat;
  logic [BE_W-1:0]   beLat;

  assign liveBank = reqAddr[COL_W+ROW_W +: BANK_W];
  assign liveRow  = reqAddr[COL_W +: ROW_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curBank <= '0;
      curRow  <= '0;
      colLat  <= '0;
      wdLat   <= '0;
      beLat   <= '0;
      rdData  <= '0;
    end else begin
      if (stb.latch) begin
        curBank <= liveBank;
        curRow  <= liveRow;
        colLat  <= reqAddr[COL_W-1:0];
        wdLat   <= reqWdata;
        beLat   <= reqBe;
      end
      if (stb.capture) rdData <= sdDqIn;
    end
  end

  always_comb begin
    sdCsN  = 1'b0;
    sdRasN = 1'b1;
    sdCasN = 1'b1;
    sdWeN  = 1'b1;
    sdDqm  = '1;
    sdDqOe = 1'b0;
    unique case (stb.cmd)
      CMD_ACT: sdRasN = 1'b0;
      CMD_RD:  begin sdCasN = 1'b0; sdDqm = '0; end
      CMD_WR:  begin sdCasN = 1'b0; sdWeN = 1'b0; sdDqm = ~beLat; sdDqOe = 1'b1; end
      CMD_PRE: begin sdRasN = 1'b0; sdWeN = 1'b0; end
      default: ;
    endcase
  end

  assign sdA10   = stb.a10;
  assign sdBank  = curBank;
  assign sdAddr  = stb.selRow ? curRow : ROW_W'(colLat);
  assign sdDqOut = wdLat;
endmodule

// File: rtl/sdram_open_row_seq.sv
module sdram_open_row_seq
  import sdram_seq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int DATA_W = 16,
  parameter int T_RCD  = 2,
  parameter int T_RP   = 3,
  parameter int T_WR   = 2,
  parameter int T_CL   = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          openMode,
  input  logic                          reqValid,
  input  logic                          reqWrite,
  input  logic [BANK_W+ROW_W+COL_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]             reqWdata,
  input  logic [DATA_W/8-1:0]           reqBe,
  output logic                          reqDone,
  output logic [DATA_W-1:0]             rdData,
  output logic                          sdCsN,
  output logic                          sdRasN,
  output logic                          sdCasN,
  output logic                          sdWeN,
  output logic                          sdA10,
  output logic [BANK_W-1:0]             sdBank,
  output logic [ROW_W-1:0]              sdAddr,
  output logic [DATA_W/8-1:0]           sdDqm,
  output logic [DATA_W-1:0]             sdDqOut,
  output logic                          sdDqOe,
  input  logic [DATA_W-1:0]             sdDqIn
);
  seqStrobeT         stb;
  logic [BANK_W-1:0] liveBank, curBank;
  logic [ROW_W-1:0]  liveRow, curRow;

  sdram_seq_ctrl #(
    .BANK_W(BANK_W), .ROW_W(ROW_W),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_WR(T_WR), .T_CL(T_CL)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .openMode(openMode),
    .reqValid(reqValid), .reqWrite(reqWrite),
    .liveBank(liveBank), .liveRow(liveRow),
    .curBank(curBank), .curRow(curRow),
    .stb(stb), .reqDone(reqDone)
  );

  sdram_seq_dpath #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe), .sdDqIn(sdDqIn),
    .liveBank(liveBank), .liveRow(liveRow),
    .curBank(curBank), .curRow(curRow), .rdData(rdData),
    .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
    .sdA10(sdA10), .sdBank(sdBank), .sdAddr(sdAddr), .sdDqm(sdDqm),
    .sdDqOut(sdDqOut), .sdDqOe(sdDqOe)
  );
endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk #(
  parameter int T_RCD = 2,
  parameter int T_RP  = 3
) (
  input logic clk,
  input logic rstN,
  input logic openMode,
  input logic reqDone,
  input logic sdCsN,
  input logic sdRasN,
  input logic sdCasN,
  input logic sdWeN,
  input logic sdA10,
  input logic sdDqOe
);
  logic isNop, isAct, isCol, isWr, isPre;
  assign isNop = !sdCsN && sdRasN && sdCasN && sdWeN;
  assign isAct = !sdCsN && !sdRasN && sdCasN && sdWeN;
  assign isCol = !sdCsN && sdRasN && !sdCasN;
  assign isWr  = isCol && !sdWeN;
  assign isPre = !sdCsN && !sdRasN && sdCasN && !sdWeN;

  logic [7:0] sinceAct, sincePre;
  logic       actPend, prePend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceAct <= '0;
      sincePre <= '0;
      actPend  <= 1'b0;
      prePend  <= 1'b0;
    end else begin
      if (isAct)                  sinceAct <= 8'd1;
      else if (sinceAct != 8'hFF) sinceAct <= sinceAct + 8'd1;
      if (isPre)                  sincePre <= 8'd1;
      else if (sincePre != 8'hFF) sincePre <= sincePre + 8'd1;
      if (isAct)      actPend <= 1'b1;
      else if (isCol) actPend <= 1'b0;
      if (isPre)      prePend <= 1'b1;
      else if (isAct) prePend <= 1'b0;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN) reqDone |=> !reqDone); // R2
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN) reqDone |-> isNop); // R2
  AST_COL_AP_FLAG: assert property (@(posedge clk) disable iff (!rstN) isCol |-> (sdA10 == !openMode)); // R3
  AST_ACT_TO_COL: assert property (@(posedge clk) disable iff (!rstN) (isCol && actPend) |-> (sinceAct == 8'(T_RCD))); // R4
  AST_PRE_TO_ACT: assert property (@(posedge clk) disable iff (!rstN) (isAct && prePend) |-> (sincePre >= 8'(T_RP))); // R8
  AST_DQ_DRIVE: assert property (@(posedge clk) disable iff (!rstN) sdDqOe |-> isWr); // R10
endmodule

bind sdram_open_row_seq sdram_seq_chk #(.T_RCD(T_RCD), .T_RP(T_RP)) u_chk (
  .clk(clk), .rstN(rstN), .openMode(openMode), .reqDone(reqDone),
  .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
  .sdA10(sdA10), .sdDqOe(sdDqOe)
);

// File: tb/tb_sdram_open_row_seq.sv
module tb_sdram_open_row_seq;
  localparam int BANK_W = 2, ROW_W = 12, COL_W = 8, DATA_W = 16;
  localparam int T_RCD = 2, T_RP = 3, T_WR = 2, T_CL = 2;
  localparam int AW = BANK_W + ROW_W + COL_W;
  localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3, C_PRE = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic openMode = 1'b0, reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0, sdDqIn = '0;
  logic [DATA_W/8-1:0] reqBe = '0;
  logic reqDone, sdCsN, sdRasN, sdCasN, sdWeN, sdA10, sdDqOe;
  logic [DATA_W-1:0] rdData, sdDqOut;
  logic [BANK_W-1:0] sdBank;
  logic [ROW_W-1:0] sdAddr;
  logic [DATA_W/8-1:0] sdDqm;

  always #5 clk = ~clk;

  sdram_open_row_seq #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_WR(T_WR), .T_CL(T_CL)
  ) dut (
    .clk(clk), .rstN(rstN), .openMode(openMode), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe),
    .reqDone(reqDone), .rdData(rdData), .sdCsN(sdCsN), .sdRasN(sdRasN),
    .sdCasN(sdCasN), .sdWeN(sdWeN), .sdA10(sdA10), .sdBank(sdBank),
    .sdAddr(sdAddr), .sdDqm(sdDqm), .sdDqOut(sdDqOut), .sdDqOe(sdDqOe),
    .sdDqIn(sdDqIn)
  );

  int tests = 0, fails = 0;
  int cyc = 0;
  int logN = 0;
  int logCmd [64];
  int logCyc [64];
  int logAddr [64];
  int logBank [64];
  int logA10 [64];
  int logDqm [64];
  int logDq [64];
  int doneCyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int decode();
    if (sdCsN) return C_NOP;
    if (!sdRasN && sdCasN && sdWeN) return C_ACT;
    if (sdRasN && !sdCasN && sdWeN) return C_RD;
    if (sdRasN && !sdCasN && !sdWeN) return C_WR;
    if (!sdRasN && sdCasN && !sdWeN) return C_PRE;
    return C_NOP;
  endfunction

  // command monitor and read-data source, both away from the active edge
  always @(negedge clk) begin
    int c;
    sdDqIn = 16'h5A00 ^ 16'(cyc);
    c = decode();
    if (c != C_NOP && logN < 64) begin
      logCmd[logN]  = c;
      logCyc[logN]  = cyc;
      logAddr[logN] = int'(sdAddr);
      logBank[logN] = int'(sdBank);
      logA10[logN]  = int'(sdA10);
      logDqm[logN]  = int'(sdDqm);
      logDq[logN]   = sdDqOe ? int'(sdDqOut) : -1;
      logN = logN + 1;
    end
    if (reqDone) doneCyc = cyc;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input int bank, input int row, input int col,
                        input int data, input int be);
    bit got;
    logN = 0;
    got = 1'b0;
    reqWrite = wr;
    reqAddr  = {BANK_W'(bank), ROW_W'(row), COL_W'(col)};
    reqWdata = DATA_W'(data);
    reqBe    = (DATA_W/8)'(be);
    reqValid = 1'b1;
    for (int i = 0; i < 100 && !got; i++) begin
      @(negedge clk);
      if (reqDone) got = 1'b1;
    end
    reqValid = 1'b0;
    chk(got, "R2 done", int'(got), 1);
    @(negedge clk);
    chk(!reqDone, "R2 single-cycle done", int'(reqDone), 0);
  endtask

  task automatic t_reset();
    chk(decode() == C_NOP && !sdCsN, "R1 nop", decode(), C_NOP);
    chk(!reqDone, "R1 done low", int'(reqDone), 0);
    chk(!sdDqOe, "R1 oe low", int'(sdDqOe), 0);
    chk(sdDqm == 2'b11, "R1 dqm", int'(sdDqm), 3);
  endtask

  task automatic t_auto_write();
    openMode = 1'b0;
    access(1'b1, 1, 12'h123, 8'h45, 16'hBEEF, 2'b01);
    chk(logN == 2, "R3 cmd count", logN, 2);
    chk(logCmd[0] == C_ACT && logAddr[0] == 12'h123 && logBank[0] == 1, "R2 act row", logAddr[0], 12'h123);
    chk(logCmd[1] == C_WR && logA10[1] == 1, "R3 write ap", logA10[1], 1);
    chk(logAddr[1] == 8'h45 && logBank[1] == 1, "R2 col addr", logAddr[1], 8'h45);
    chk(logCyc[1] - logCyc[0] == T_RCD, "R4 rcd", logCyc[1] - logCyc[0], T_RCD);
    chk(doneCyc - logCyc[1] == T_WR + T_RP, "R4 auto write done", doneCyc - logCyc[1], T_WR + T_RP);
    chk(logDq[1] == 16'hBEEF, "R10 write data", logDq[1], 16'hBEEF);
    chk(logDqm[1] == 2'b10, "R10 dqm", logDqm[1], 2);
    chk(!sdDqOe, "R10 oe idle", int'(sdDqOe), 0);
  endtask

  task automatic t_auto_read();
    openMode = 1'b0;
    access(1'b0, 2, 12'h0AA, 8'h10, 0, 0);
    chk(logN == 2 && logCmd[0] == C_ACT && logCmd[1] == C_RD, "R3 read seq", logN, 2);
    chk(logA10[1] == 1, "R3 read ap", logA10[1], 1);
    chk(doneCyc - logCyc[1] == T_CL + 1 + T_RP, "R4 auto read done", doneCyc - logCyc[1], T_CL + 1 + T_RP);
    chk(rdData == 16'(16'h5A00 ^ 16'(logCyc[1] + T_CL)), "R11 read data", int'(rdData),
        int'(16'h5A00 ^ 16'(logCyc[1] + T_CL)));
  endtask

  task automatic t_open_empty();
    openMode = 1'b1;
    access(1'b1, 0, 12'h200, 8'h03, 16'h1234, 2'b11);
    chk(logN == 2 && logCmd[0] == C_ACT && logCmd[1] == C_WR, "R6 empty seq", logN, 2);
    chk(logA10[1] == 0, "R5 no ap", logA10[1], 0);
    chk(doneCyc - logCyc[1] == T_WR, "R4 open write done", doneCyc - logCyc[1], T_WR);
  endtask

  task automatic t_open_hit();
    access(1'b0, 0, 12'h200, 8'h07, 0, 0);
    chk(logN == 1 && logCmd[0] == C_RD, "R7 hit seq", logN, 1);
    chk(logA10[0] == 0 && logAddr[0] == 7, "R5 hit col", logAddr[0], 7);
    chk(doneCyc - logCyc[0] == T_CL + 1, "R4 open read done", doneCyc - logCyc[0], T_CL + 1);
  endtask

  task automatic t_other_bank();
    access(1'b1, 3, 12'h050, 8'h01, 16'h5555, 2'b10);
    chk(logN == 2 && logCmd[0] == C_ACT && logBank[0] == 3, "R9 other bank act", logN, 2);
    access(1'b0, 0, 12'h200, 8'h02, 0, 0);
    chk(logN == 1 && logCmd[0] == C_RD && logBank[0] == 0, "R9 bank0 still open", logN, 1);
  endtask

  task automatic t_miss();
    access(1'b1, 0, 12'h201, 8'h09, 16'hCAFE, 2'b11);
    chk(logN == 3, "R8 miss count", logN, 3);
    chk(logCmd[0] == C_PRE && logA10[0] == 0 && logBank[0] == 0, "R8 pre bank", logCmd[0], C_PRE);
    chk(logCmd[1] == C_ACT && logAddr[1] == 12'h201, "R8 act new row", logAddr[1], 12'h201);
    chk(logCyc[1] - logCyc[0] == T_RP, "R8 rp gap", logCyc[1] - logCyc[0], T_RP);
    chk(logCmd[2] == C_WR && logCyc[2] - logCyc[1] == T_RCD, "R8 col after act", logCyc[2] - logCyc[1], T_RCD);
  endtask

  task automatic t_mode_clear();
    openMode = 1'b0;
    access(1'b1, 3, 12'h050, 8'h04, 16'h0F0F, 2'b11);
    chk(logN == 3 && logCmd[0] == C_PRE && logA10[0] == 1, "R12 precharge all", logA10[0], 1);
    chk(logCmd[1] == C_ACT && logCmd[2] == C_WR && logA10[2] == 1, "R12 auto after clear", logCmd[1], C_ACT);
    openMode = 1'b1;
    access(1'b0, 0, 12'h201, 8'h05, 0, 0);
    chk(logN == 2 && logCmd[0] == C_ACT, "R12 rows forgotten", logCmd[0], C_ACT);
  endtask

  task automatic t_reset_forget();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    access(1'b0, 0, 12'h201, 8'h06, 0, 0);
    chk(logN == 2 && logCmd[0] == C_ACT && logCmd[1] == C_RD, "R13 reset closes rows", logCmd[0], C_ACT);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_auto_write();
    t_auto_read();
    t_open_empty();
    t_open_hit();
    t_other_bank();
    t_miss();
    t_mode_clear();
    t_reset_forget();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule